// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 96 interrupt sources into one interrupt line for the CPU. The sources come in three 32-bit groups. Two main words (low, sources 0–31, and high, sources 32–63) take level inputs directly. A pin group (sources 64–95) latches rising edges on 32 input pins. Each group is gated by its own mask register, where a 1 enables the source. The pin group does not drive the CPU line itself. It cascades into four summary bits of the high main word, and those bits are then gated by the high mask like any other high source.

Software reaches the registers over a simple 32-bit write strobe and address bus, and reads combinationally through `bus_rdata`. Address bit 7 selects the pin unit. A select-cause register returns the pending word that should be serviced next and flags whether that word is the high one. A helper output gives the encoded number of the highest pending source, so that a handler can dispatch without walking the registers.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, the low mask reads 0x00000000, the pin mask reads 0x00000000, the pin cause reads 0x00000000, and the high mask reads 0x0F000000, so that the four summary bits are enabled.
- R2: Main cause low (address 0x04) reads the level of main inputs 31:0, and main cause high (address 0x0C) reads main inputs 63:32 apart from bits 27:24. Writes to either address have no effect.
- R3: In the high cause, bit 24+g is set exactly when pin group g (pins 8g to 8g+7) has a cause bit that is also set in the pin mask. Main inputs 59:56 are ignored.
- R4: A pin cause bit (address 0x88) sets in the clock after its pin goes from 0 to 1. A pin that stays high does not set the bit again once it has been cleared.
- R5: A write to address 0x88 clears each cause bit written as 0 and keeps each bit written as 1. A rising edge in the same cycle as the write keeps its bit set.
- R6: The mask registers at 0x14 (low), 0x1C (high) and 0x8C (pins) read back the last value written. A mask bit of 1 enables its source.
- R7: `cpu_irq` is 1 exactly when (cause low AND mask low) or (cause high AND mask high) is nonzero.
- R8: Reading select-cause (0x24) returns the pending low word (cause AND mask) with bit 30 forced to 0 whenever that word is nonzero. Otherwise it returns the pending high word with bit 30 forced to 1 when that word is nonzero, and 0 when nothing is pending.
- R9: `src_id` gives the group in bits 6:5 (0 = low, 1 = high, 2 = pins) and the highest set pending bit of that group in bits 4:0. The low group is chosen before the high group.
- R10: When the low word has nothing pending and the pending high word has a summary bit set, `src_id` reports group 2 with the highest set bit of (pin cause AND pin mask).
- R11: `src_valid` is 0 and `src_id` is 0 when nothing is pending. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address; bit 7 selects the pin unit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_main | input | 64 | Level inputs of the main low and high words |
| gpp_pin | input | 32 | Edge-latched pin inputs |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| src_valid | output | 1 | Something is pending |
| src_id | output | 7 | Encoded number of the highest pending source |

## Verification
The hardest case to reach is a pin edge that arrives in the same cycle as a write-to-clear of the pin cause, together with a pin that is held high across a clear. The bench lines up a pin rise with the clearing write on one clock edge, and clears a bit while its pin stays high. A behavioural model tracks the pin history on every clock. Further sequences mask the summary bits in the high mask while pin causes stay latched, and raise low and high sources together, so that the select-cause and encoder priorities are tested in both directions.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int IDX_W       = $clog2(WORD_W);
    localparam int GRP_W       = 2;
    localparam int SRC_W       = GRP_W + IDX_W;
    localparam int PIN_GROUPS  = 4;
    localparam int SUM_LSB     = 24;
    localparam int SEL_FLAG    = 30;

    localparam logic [ADDR_W-1:0] A_CAUSE_LO = 8'h04;
    localparam logic [ADDR_W-1:0] A_CAUSE_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MASK_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] A_MASK_HI  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_SELECT   = 8'h24;
    localparam logic [ADDR_W-1:0] A_PIN_CAUSE = 8'h88;
    localparam logic [ADDR_W-1:0] A_PIN_MASK  = 8'h8C;

    localparam logic [WORD_W-1:0] SUM_FIELD   = {{(WORD_W-PIN_GROUPS){1'b0}}, {PIN_GROUPS{1'b1}}} << SUM_LSB;
    localparam logic [WORD_W-1:0] MASK_HI_RST = SUM_FIELD;

    typedef enum logic [GRP_W-1:0] {
        GRP_LOW  = 2'd0,
        GRP_HIGH = 2'd1,
        GRP_PIN  = 2'd2
    } grp_e;

    typedef struct packed {
        grp_e             grp;
        logic [IDX_W-1:0] idx;
    } src_id_t;

    // index of the highest set bit, zero for an empty word
    function automatic logic [IDX_W-1:0] top_bit(input logic [WORD_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (v[i]) r = i[IDX_W-1:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_pin_unit.sv
module irq_pin_unit
    import irq_pkg::*;
#(
    parameter int PINS   = WORD_W,
    parameter int GROUPS = PIN_GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin,
    input  logic              cause_we,
    input  logic              mask_we,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   cause,
    output logic [PINS-1:0]   mask,
    output logic [PINS-1:0]   pend,
    output logic [GROUPS-1:0] summary
);
    localparam int PER = PINS / GROUPS;

    logic [PINS-1:0] pin_q;
    logic [PINS-1:0] rise;
    logic [PINS-1:0] cause_kept;

    assign rise       = pin & ~pin_q;
    assign cause_kept = cause_we ? (cause & wdata) : cause;
    assign pend       = cause & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= '0;
            cause <= '0;
            mask  <= '0;
        end else begin
            pin_q <= pin;
            cause <= cause_kept | rise;
            if (mask_we) mask <= wdata;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_sum
        assign summary[g] = |pend[g*PER +: PER];
    end
endmodule

// File: rtl/irq_main_unit.sv
module irq_main_unit
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*WORD_W-1:0]   irq_main,
    input  logic [PIN_GROUPS-1:0] pin_sum,
    input  logic                  mask_lo_we,
    input  logic                  mask_hi_we,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     cause_lo,
    output logic [WORD_W-1:0]     cause_hi,
    output logic [WORD_W-1:0]     mask_lo,
    output logic [WORD_W-1:0]     mask_hi,
    output logic [WORD_W-1:0]     pend_lo,
    output logic [WORD_W-1:0]     pend_hi,
    output logic [WORD_W-1:0]     sel_word,
    output logic                  irq
);
    logic [WORD_W-1:0] hi_raw;
    logic [WORD_W-1:0] sum_word;

    assign hi_raw   = irq_main[2*WORD_W-1:WORD_W];
    assign sum_word = {{(WORD_W-PIN_GROUPS){1'b0}}, pin_sum} << SUM_LSB;
    assign cause_lo = irq_main[WORD_W-1:0];
    assign cause_hi = (hi_raw & ~SUM_FIELD) | sum_word;
    assign pend_lo  = cause_lo & mask_lo;
    assign pend_hi  = cause_hi & mask_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_lo <= '0;
            mask_hi <= MASK_HI_RST;
        end else begin
            if (mask_lo_we) mask_lo <= wdata;
            if (mask_hi_we) mask_hi <= wdata;
        end
    end

    always_comb begin
        sel_word = '0;
        if (|pend_lo) begin
            sel_word           = pend_lo;
            sel_word[SEL_FLAG] = 1'b0;
        end else if (|pend_hi) begin
            sel_word           = pend_hi;
            sel_word[SEL_FLAG] = 1'b1;
        end
    end

    assign irq = (|pend_lo) | (|pend_hi);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_pkg::*;
(
    input  logic [WORD_W-1:0] pend_lo,
    input  logic [WORD_W-1:0] pend_hi,
    input  logic [WORD_W-1:0] pend_pin,
    output logic              valid,
    output src_id_t           id
);
    always_comb begin
        valid  = 1'b1;
        id.grp = GRP_LOW;
        id.idx = '0;
        if (|pend_lo) begin
            id.grp = GRP_LOW;
            id.idx = top_bit(pend_lo);
        end else if (|(pend_hi & SUM_FIELD)) begin
            id.grp = GRP_PIN;
            id.idx = top_bit(pend_pin);
        end else if (|pend_hi) begin
            id.grp = GRP_HIGH;
            id.idx = top_bit(pend_hi);
        end else begin
            valid = 1'b0;
        end
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [2*WORD_W-1:0] irq_main,
    input  logic [WORD_W-1:0]   gpp_pin,
    output logic                cpu_irq,
    output logic                src_valid,
    output logic [SRC_W-1:0]    src_id
);
    logic [WORD_W-1:0]     gpp_cause, gpp_mask, gpp_pend;
    logic [PIN_GROUPS-1:0] gpp_sum;
    logic [WORD_W-1:0]     cause_lo, cause_hi, mask_lo, mask_hi;
    logic [WORD_W-1:0]     pend_lo, pend_hi, sel_word;
    src_id_t               enc_id;

    logic we_pin_cause, we_pin_mask, we_mask_lo, we_mask_hi;
    assign we_pin_cause = bus_wr && (bus_addr == A_PIN_CAUSE);
    assign we_pin_mask  = bus_wr && (bus_addr == A_PIN_MASK);
    assign we_mask_lo   = bus_wr && (bus_addr == A_MASK_LO);
    assign we_mask_hi   = bus_wr && (bus_addr == A_MASK_HI);

    irq_pin_unit #(.PINS(WORD_W), .GROUPS(PIN_GROUPS)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin      (gpp_pin),
        .cause_we (we_pin_cause),
        .mask_we  (we_pin_mask),
        .wdata    (bus_wdata),
        .cause    (gpp_cause),
        .mask     (gpp_mask),
        .pend     (gpp_pend),
        .summary  (gpp_sum)
    );

    irq_main_unit u_main (
        .clk        (clk),
        .rst        (rst),
        .irq_main   (irq_main),
        .pin_sum    (gpp_sum),
        .mask_lo_we (we_mask_lo),
        .mask_hi_we (we_mask_hi),
        .wdata      (bus_wdata),
        .cause_lo   (cause_lo),
        .cause_hi   (cause_hi),
        .mask_lo    (mask_lo),
        .mask_hi    (mask_hi),
        .pend_lo    (pend_lo),
        .pend_hi    (pend_hi),
        .sel_word   (sel_word),
        .irq        (cpu_irq)
    );

    irq_prio_enc u_enc (
        .pend_lo  (pend_lo),
        .pend_hi  (pend_hi),
        .pend_pin (gpp_pend),
        .valid    (src_valid),
        .id       (enc_id)
    );

    assign src_id = enc_id;

    always_comb begin
        unique case (bus_addr)
            A_CAUSE_LO:  bus_rdata = cause_lo;
            A_CAUSE_HI:  bus_rdata = cause_hi;
            A_MASK_LO:   bus_rdata = mask_lo;
            A_MASK_HI:   bus_rdata = mask_hi;
            A_SELECT:    bus_rdata = sel_word;
            A_PIN_CAUSE: bus_rdata = gpp_cause;
            A_PIN_MASK:  bus_rdata = gpp_mask;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk
    import irq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [WORD_W-1:0]   gpp_pin,
    input logic                cpu_irq,
    input logic                src_valid,
    input logic [SRC_W-1:0]    src_id,
    input logic [WORD_W-1:0]   gpp_cause,
    input logic [WORD_W-1:0]   gpp_mask,
    input logic [WORD_W-1:0]   mask_lo,
    input logic [WORD_W-1:0]   mask_hi
);
    // R1
    reset_masks_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> (mask_lo == '0 && gpp_mask == '0 &&
                                gpp_cause == '0 && mask_hi == MASK_HI_RST));

    // R4
    pin_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        (gpp_cause & ~$past(gpp_cause) & ~$past(gpp_pin)) == '0);

    // R6
    mask_lo_wr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_MASK_LO |=> mask_lo == $past(bus_wdata));

    // R7
    irq_matches_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == src_valid);

    // R10
    pin_id_pending_chk: assert property (@(posedge clk) disable iff (rst)
        src_valid && src_id[SRC_W-1:IDX_W] == GRP_PIN |->
            (gpp_cause[src_id[IDX_W-1:0]] && gpp_mask[src_id[IDX_W-1:0]]));

    // R11
    idle_id_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !src_valid |-> src_id == '0);

    // R9
    group_code_chk: assert property (@(posedge clk) disable iff (rst)
        src_valid |-> src_id[SRC_W-1:IDX_W] != 2'd3);
endmodule

bind casc_irq_ctrl casc_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .gpp_pin   (gpp_pin),
    .cpu_irq   (cpu_irq),
    .src_valid (src_valid),
    .src_id    (src_id),
    .gpp_cause (gpp_cause),
    .gpp_mask  (gpp_mask),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi)
);

// File: tb/sim_casc_irq_ctrl.sv
module sim_casc_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] irq_main = '0;
    logic [31:0] gpp_pin = '0;
    logic        cpu_irq;
    logic        src_valid;
    logic [6:0]  src_id;

    int checks = 0;
    int fails  = 0;
    bit armed  = 0;
    bit done   = 0;

    // behavioural reference state
    logic [31:0] r_lo_mask, r_hi_mask, r_pin_mask, r_pin_cause, r_pin_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_main(irq_main),
        .gpp_pin(gpp_pin), .cpu_irq(cpu_irq), .src_valid(src_valid), .src_id(src_id)
    );

    always @(posedge clk) begin
        if (rst) begin
            r_lo_mask = 0; r_hi_mask = 32'h0F00_0000; r_pin_mask = 0;
            r_pin_cause = 0; r_pin_prev = 0;
        end else begin
            logic [31:0] nxt;
            nxt = r_pin_cause;
            if (bus_wr && bus_addr == 8'h88) nxt = nxt & bus_wdata;
            for (int i = 0; i < 32; i++)
                if (gpp_pin[i] && !r_pin_prev[i]) nxt[i] = 1'b1;
            if (bus_wr && bus_addr == 8'h14) r_lo_mask = bus_wdata;
            if (bus_wr && bus_addr == 8'h1C) r_hi_mask = bus_wdata;
            if (bus_wr && bus_addr == 8'h8C) r_pin_mask = bus_wdata;
            r_pin_cause = nxt;
            r_pin_prev  = gpp_pin;
        end
    end

    function automatic logic [31:0] m_hi_cause();
        logic [31:0] w;
        for (int i = 0; i < 32; i++) begin
            if (i >= 24 && i < 28) begin
                w[i] = 1'b0;
                for (int p = (i-24)*8; p < (i-23)*8; p++)
                    if (r_pin_cause[p] && r_pin_mask[p]) w[i] = 1'b1;
            end else w[i] = irq_main[32+i];
        end
        return w;
    endfunction

    function automatic int hi_idx(input logic [31:0] v);
        int r = 0;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [31:0] plo, phi, ppin, sel, rd;
            int id; bit v;
            string tag;
            plo  = irq_main[31:0] & r_lo_mask;
            phi  = m_hi_cause() & r_hi_mask;
            ppin = r_pin_cause & r_pin_mask;
            v = (plo != 0) || (phi != 0);
            check("R7 cpu_irq", {31'b0, cpu_irq}, {31'b0, v});
            check("R11 src_valid", {31'b0, src_valid}, {31'b0, v});
            id = 0; tag = "R11 src_id idle";
            if (plo != 0) begin id = hi_idx(plo); tag = "R9 src_id low"; end
            else if ((phi & 32'h0F00_0000) != 0) begin id = 64 + hi_idx(ppin); tag = "R10 src_id pin"; end
            else if (phi != 0) begin id = 32 + hi_idx(phi); tag = "R9 src_id high"; end
            check(tag, {25'b0, src_id}, id);
            sel = 0;
            if (plo != 0) begin sel = plo; sel[30] = 1'b0; end
            else if (phi != 0) begin sel = phi; sel[30] = 1'b1; end
            case (bus_addr)
                8'h04: begin rd = irq_main[31:0]; tag = "R2 cause low"; end
                8'h0C: begin rd = m_hi_cause(); tag = "R3 cause high"; end
                8'h14: begin rd = r_lo_mask; tag = "R6 mask low"; end
                8'h1C: begin rd = r_hi_mask; tag = "R6 mask high"; end
                8'h24: begin rd = sel; tag = "R8 select"; end
                8'h88: begin rd = r_pin_cause; tag = "R4 pin cause"; end
                8'h8C: begin rd = r_pin_mask; tag = "R6 pin mask"; end
                default: begin rd = 0; tag = "R11 unmapped"; end
            endcase
            check(tag, bus_rdata, rd);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd_at(input logic [7:0] a);
        bus_addr = a;
        cyc(1);
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        armed = 1;
        // R1 reset values through the bus
        bus_addr = 8'h14; #1 check("R1 low mask reset", bus_rdata, 32'h0);
        bus_addr = 8'h1C; #1 check("R1 high mask reset", bus_rdata, 32'h0F00_0000);
        bus_addr = 8'h8C; #1 check("R1 pin mask reset", bus_rdata, 32'h0);
        bus_addr = 8'h88; #1 check("R1 pin cause reset", bus_rdata, 32'h0);
        cyc(1);

        // R2 level inputs, masked then enabled
        irq_main = 64'h0000_0001_8000_0011;
        rd_at(8'h04); rd_at(8'h0C); rd_at(8'h24);
        wr(8'h14, 32'h0000_0010);
        rd_at(8'h24);
        wr(8'h04, 32'hFFFF_FFFF);  // ignored
        rd_at(8'h04);
        wr(8'h1C, 32'h0F00_0001);
        irq_main = 64'h0000_0001_0000_0000;
        rd_at(8'h24);
        // R9 low beats high
        irq_main = 64'h0000_0001_0000_0010;
        rd_at(8'h24);
        irq_main = 64'h0000_0001_0000_0000;
        // R3 main inputs 59:56 ignored
        irq_main = 64'h0F00_0000_0000_0000;
        rd_at(8'h0C);
        check("R3 summary ignores inputs", {31'b0, cpu_irq}, 32'h0);
        irq_main = 64'h0;

        // R4 pin edge latches, masked first
        gpp_pin = 32'h0000_0100;
        rd_at(8'h88);
        check("R4 pin latched", bus_rdata, 32'h0000_0100);
        rd_at(8'h0C);
        wr(8'h8C, 32'h0000_0300);
        rd_at(8'h0C);
        check("R10 pin id", {25'b0, src_id}, 32'd72);
        rd_at(8'h24);
        // clear while pin still high: stays clear
        wr(8'h88, ~32'h0000_0100);
        rd_at(8'h88);
        check("R4 held pin no relatch", bus_rdata, 32'h0);
        gpp_pin = 32'h0;
        cyc(1);
        // R5 edge in the same cycle as a clear of that bit
        bus_wr = 1'b1; bus_addr = 8'h88; bus_wdata = ~32'h0000_0200; gpp_pin = 32'h0000_0200;
        cyc(1);
        bus_wr = 1'b0;
        rd_at(8'h88);
        check("R5 edge wins over clear", bus_rdata, 32'h0000_0200);
        // R5 write of ones keeps bits, single zero clears one bit
        gpp_pin = 32'h8000_0201;
        cyc(1);
        wr(8'h88, 32'hFFFF_FFFF);
        rd_at(8'h88);
        check("R5 ones keep", bus_rdata, 32'h8000_0201);
        wr(8'h88, ~32'h0000_0001);
        rd_at(8'h88);
        check("R5 one-hot clear", bus_rdata, 32'h8000_0200);
        wr(8'h8C, 32'hFFFF_FFFF);
        rd_at(8'h0C);
        check("R10 highest pin", {25'b0, src_id}, 32'd95);
        // R6 summary disabled in high mask, high source remains
        irq_main = 64'h0000_0004_0000_0000;
        wr(8'h1C, 32'h0000_0004);
        rd_at(8'h24);
        check("R9 high id", {25'b0, src_id}, 32'd34);
        irq_main = 64'h0;
        cyc(1);
        check("R11 idle", {31'b0, src_valid}, 32'h0);
        rd_at(8'h40);
        gpp_pin = 32'h0;
        wr(8'h1C, 32'h0F00_0000);
        rd_at(8'h24);
        wr(8'h88, 32'h0);
        rd_at(8'h24);
        check("R8 select empty", bus_rdata, 32'h0);
        cyc(2);
        summary();
        $finish;
    end
endmodule